// File: doc/BRIEF.md
# Byte-Lane Bus Parity Generator and Checker

This block sits between a bus master's 32-bit data path and a memory bus that carries one parity bit per byte lane. On the write side it produces an even parity bit for each of the four data bytes. The bits are purely combinational from the write data, so they appear in the same cycle as the data. Even in 16-bit bus mode all four parity bits are generated, because all 32 data lines are driven on writes.

On the read side the block captures the returned data and parity bits at the clock edge where ready is seen during a read cycle. It also captures the lane mask, which is the byte enables limited to the lower two lanes when the narrow-bus input is set. In the following clock it reports the result on an active-low status pin. The pin is low when any checked lane holds an odd number of ones across its byte and parity bit. It is high when all checked lanes are correct, and high at every other time. Lanes that are not enabled never cause an error.

Top module: `lane_parity_unit`

## Requirements
- R1: `wpar[i]` is the even-parity bit of byte lane i, where lane i is `wdata[8*i+7:8*i]`. The byte together with `wpar[i]` always holds an even number of ones.
- R2: `wpar` is combinational from `wdata` and is valid in the same cycle. All four bits are produced whatever the values of `narrow_bus`, `rd_cycle` and `byte_en`.
- R3: The check uses `rdata`, `rpar`, `byte_en` and `narrow_bus` as sampled at the rising edge where `rdy` and `rd_cycle` are both 1. The result appears on `chk_n` for the clock that follows that edge. Input changes after that edge do not alter it.
- R4: `chk_n` is 0 in that result clock if at least one checked lane has an odd count of ones over `rdata` lane i plus `rpar[i]`. It is 1 if every checked lane is even.
- R5: A lane whose `byte_en` bit is 0 is never checked, so bad parity on it leaves `chk_n` at 1.
- R6: With `narrow_bus` = 1 only lanes 0 and 1 can be checked, each qualified by `byte_en[0]` and `byte_en[1]`. Lanes 2 and 3 are ignored even when enabled.
- R7: `chk_n` is 1 in any clock that does not follow a ready edge of a read cycle. That covers edges where `rdy` is 0 and edges where `rdy` is 1 with `rd_cycle` = 0 (a write).
- R8: The result lasts one clock only. Back-to-back read edges each give their own result, and after a single read `chk_n` returns to 1 in the next clock.
- R9: Synchronous active-high `rst` forces `chk_n` to 1 in the following clock and clears the captured data, parity and mask. It takes priority over a read edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdy | input | 1 | Transfer-complete handshake |
| rd_cycle | input | 1 | 1 = current cycle is a read, 0 = write |
| narrow_bus | input | 1 | 1 = 16-bit bus mode, 0 = 32-bit |
| byte_en | input | 4 | Active-high byte-lane enables, bit i = lane i |
| wdata | input | 32 | Outgoing write data |
| rdata | input | 32 | Returned read data |
| rpar | input | 4 | Returned even parity, bit i for lane i |
| wpar | output | 4 | Generated even parity for wdata, bit i for lane i |
| chk_n | output | 1 | Read parity status, low = error, one clock after ready |

## Verification
The bench aims at lanes that carry bad parity but are masked, either by a cleared enable or by narrow mode on an upper lane. A design that ignored either qualifier would pull `chk_n` low there. It issues back-to-back reads with alternating outcomes and a write with ready that follows a bad read. These catch a result that is stretched, delayed or taken from the wrong edge. It also asserts reset in the same cycle as a failing read, so a design that let the read win would drive the pin low. Random words with random parity flips compare every write parity bit and every read result against bench functions.

// File: rtl/lpar_pkg.sv
package lpar_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned LW = 8;
  localparam int unsigned NL = DW / LW;
  localparam int unsigned NARROW_NL = NL / 2;

  typedef logic [NL-1:0] lane_vec_t;

  // even parity bit for one byte lane
  function automatic logic lane_even_bit(input logic [LW-1:0] b);
    return ^b;
  endfunction

  // lanes taking part in a read check
  function automatic lane_vec_t lane_select(input lane_vec_t en, input logic narrow);
    lane_vec_t m;
    for (int i = 0; i < NL; i++) begin
      m[i] = en[i] && (!narrow || (i < NARROW_NL));
    end
    return m;
  endfunction
endpackage

// File: rtl/lpar_gen.sv
module lpar_gen #(
  parameter int unsigned DW = lpar_pkg::DW,
  parameter int unsigned LW = lpar_pkg::LW,
  localparam int unsigned NL = DW / LW
) (
  input  logic [DW-1:0] data,
  output logic [NL-1:0] par
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign par[i] = lpar_pkg::lane_even_bit(data[i*LW +: LW]);
  end
endmodule

// File: rtl/lpar_capture.sv
module lpar_capture #(
  parameter int unsigned DW = lpar_pkg::DW,
  parameter int unsigned LW = lpar_pkg::LW,
  localparam int unsigned NL = DW / LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  input  logic [NL-1:0] pin,
  input  logic [NL-1:0] min,
  output logic [DW-1:0] dq,
  output logic [NL-1:0] pq,
  output logic [NL-1:0] mq,
  output logic          vq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dq <= '0;
      pq <= '0;
      mq <= '0;
      vq <= 1'b0;
    end else begin
      vq <= strobe;
      if (strobe) begin
        dq <= din;
        pq <= pin;
        mq <= min;
      end
    end
  end
endmodule

// File: rtl/lpar_eval.sv
module lpar_eval #(
  parameter int unsigned DW = lpar_pkg::DW,
  parameter int unsigned LW = lpar_pkg::LW,
  localparam int unsigned NL = DW / LW
) (
  input  logic [DW-1:0] data,
  input  logic [NL-1:0] par,
  input  logic [NL-1:0] mask,
  input  logic          valid,
  output logic [NL-1:0] lane_bad,
  output logic          stat_n
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign lane_bad[i] = mask[i] &&
      (lpar_pkg::lane_even_bit(data[i*LW +: LW]) != par[i]);
  end
  assign stat_n = !(valid && (|lane_bad));
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
  parameter int unsigned DW = lpar_pkg::DW,
  parameter int unsigned LW = lpar_pkg::LW,
  localparam int unsigned NL = DW / LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rdy,
  input  logic          rd_cycle,
  input  logic          narrow_bus,
  input  logic [NL-1:0] byte_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rdata,
  input  logic [NL-1:0] rpar,
  output logic [NL-1:0] wpar,
  output logic          chk_n
);
  // named internal events
  logic          rd_strobe;
  logic [NL-1:0] lane_mask;
  logic [DW-1:0] cap_data;
  logic [NL-1:0] cap_par;
  logic [NL-1:0] cap_mask;
  logic          cap_valid;
  logic [NL-1:0] lane_err;

  assign rd_strobe = rdy && rd_cycle;
  assign lane_mask = lpar_pkg::lane_select(byte_en, narrow_bus);

  lpar_gen #(.DW(DW), .LW(LW)) u_gen (
    .data(wdata),
    .par (wpar)
  );

  lpar_capture #(.DW(DW), .LW(LW)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .strobe(rd_strobe),
    .din   (rdata),
    .pin   (rpar),
    .min   (lane_mask),
    .dq    (cap_data),
    .pq    (cap_par),
    .mq    (cap_mask),
    .vq    (cap_valid)
  );

  lpar_eval #(.DW(DW), .LW(LW)) u_eval (
    .data    (cap_data),
    .par     (cap_par),
    .mask    (cap_mask),
    .valid   (cap_valid),
    .lane_bad(lane_err),
    .stat_n  (chk_n)
  );
endmodule

// File: rtl/lpar_chk.sv
module lpar_chk #(
  parameter int unsigned DW = lpar_pkg::DW,
  parameter int unsigned LW = lpar_pkg::LW,
  localparam int unsigned NL = DW / LW
) (
  input logic          clk,
  input logic          rst,
  input logic          rdy,
  input logic          rd_cycle,
  input logic          narrow_bus,
  input logic [NL-1:0] byte_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [NL-1:0] rpar,
  input logic [NL-1:0] wpar,
  input logic          chk_n,
  input logic          cap_valid
);
  logic [NL-1:0] odd_in;
  logic [NL-1:0] live_in;
  for (genvar i = 0; i < NL; i++) begin : g_l
    assign odd_in[i]  = ($countones({rdata[i*LW +: LW], rpar[i]}) % 2) == 1;
    assign live_in[i] = byte_en[i] && !(narrow_bus && i >= NL / 2);

    assert_wpar_even_R1: assert property (@(posedge clk) disable iff (rst)
      ($countones({wdata[i*LW +: LW], wpar[i]}) % 2) == 0);
  end

  assert_low_needs_read_R3: assert property (@(posedge clk) disable iff (rst)
    !chk_n |-> $past(rdy && rd_cycle));

  assert_error_reported_R4: assert property (@(posedge clk) disable iff (rst)
    (rdy && rd_cycle && (odd_in & live_in) != '0) |=> !chk_n);

  assert_masked_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (rdy && rd_cycle && (odd_in & live_in) == '0) |=> chk_n);

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
    !(rdy && rd_cycle) |=> (chk_n && !cap_valid));

  assert_reset_high_R9: assert property (@(posedge clk)
    rst |=> (chk_n && !cap_valid));
endmodule

bind lane_parity_unit lpar_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rdy       (rdy),
  .rd_cycle  (rd_cycle),
  .narrow_bus(narrow_bus),
  .byte_en   (byte_en),
  .wdata     (wdata),
  .rdata     (rdata),
  .rpar      (rpar),
  .wpar      (wpar),
  .chk_n     (chk_n),
  .cap_valid (cap_valid)
);

// File: tb/sim_lane_parity_unit.sv
module sim_lane_parity_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, rdy, rd_cycle, narrow_bus;
  logic [3:0]  byte_en, rpar, wpar;
  logic [31:0] wdata, rdata;
  logic        chk_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic  exp_next;
  string tag_next;

  always #(PERIOD/2) clk = ~clk;

  lane_parity_unit u0 (
    .clk(clk), .rst(rst), .rdy(rdy), .rd_cycle(rd_cycle),
    .narrow_bus(narrow_bus), .byte_en(byte_en), .wdata(wdata),
    .rdata(rdata), .rpar(rpar), .wpar(wpar), .chk_n(chk_n)
  );

  function automatic logic [3:0] ref_par(input logic [31:0] d);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) p[k] = ($countones(d[8*k +: 8]) % 2) == 1;
    return p;
  endfunction

  function automatic logic ref_stat(input logic [31:0] d, input logic [3:0] p,
                                    input logic [3:0] en, input logic nb);
    for (int k = 0; k < 4; k++) begin
      if (en[k] && !(nb && k > 1) && (($countones(d[8*k +: 8]) + p[k]) % 2 == 1))
        return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // check the pending result, then drive one cycle of inputs
  task automatic cyc(input string tag, input logic r, input logic rd_, input logic rc,
                     input logic nb, input logic [3:0] en, input logic [31:0] wd,
                     input logic [31:0] rdd, input logic [3:0] rp);
    @(negedge clk);
    check1(tag_next, {31'd0, chk_n}, {31'd0, exp_next});
    rst = r; rdy = rd_; rd_cycle = rc; narrow_bus = nb;
    byte_en = en; wdata = wd; rdata = rdd; rpar = rp;
    #1;
    check1(nb ? "R2 wpar narrow" : "R1 wpar", {28'd0, wpar}, {28'd0, ref_par(wd)});
    if (r) exp_next = 1'b1;
    else if (rd_ && rc) exp_next = ref_stat(rdd, rp, en, nb);
    else exp_next = 1'b1;
    tag_next = tag;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  good;
    void'($urandom(32'd5150));
    rst = 1; rdy = 0; rd_cycle = 0; narrow_bus = 0; byte_en = 0;
    wdata = 0; rdata = 0; rpar = 0;
    exp_next = 1'b1; tag_next = "R9 reset";
    repeat (3) @(posedge clk);
    cyc("R9 reset state", 1, 0, 0, 0, 4'h0, 32'h0, 32'h0, 4'h0);
    d = 32'h01_03_07_FF; good = ref_par(d);
    // R4 good read, full lanes
    cyc("R4 all lanes good", 0, 1, 1, 0, 4'hF, d, d, good);
    // R4 error on lane 2; R8 back-to-back with opposite result
    cyc("R4 lane2 bad", 0, 1, 1, 0, 4'hF, d, d, good ^ 4'b0100);
    cyc("R8 back-to-back good", 0, 1, 1, 0, 4'hF, d, d, good);
    cyc("R8 back-to-back bad", 0, 1, 1, 0, 4'hF, d, d, good ^ 4'b0001);
    // R7 write with ready after bad read; R3 inputs changed afterwards
    cyc("R7 write with ready", 0, 1, 0, 0, 4'hF, d, d, ~good);
    cyc("R7 no ready", 0, 0, 1, 0, 4'hF, d, d, ~good);
    cyc("R8 return high", 0, 0, 0, 0, 4'h0, 32'h0, 32'h0, 4'h0);
    // R5 disabled lane carries error
    cyc("R5 disabled lane3 bad", 0, 1, 1, 0, 4'b0111, d, d, good ^ 4'b1000);
    cyc("R5 no lanes enabled", 0, 1, 1, 0, 4'b0000, d, d, ~good);
    // R6 narrow mode
    cyc("R6 narrow upper bad ignored", 0, 1, 1, 1, 4'hF, d, d, good ^ 4'b1100);
    cyc("R6 narrow lane1 bad", 0, 1, 1, 1, 4'b0010, d, d, good ^ 4'b0010);
    cyc("R6 narrow lane0 masked", 0, 1, 1, 1, 4'b0010, d, d, good ^ 4'b0001);
    // R9 reset wins over a failing read
    cyc("R9 reset over read", 1, 1, 1, 0, 4'hF, d, d, ~good);
    cyc("R3 after reset", 0, 0, 0, 0, 4'h0, 32'h0, 32'h0, 4'h0);
    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] rw, rr;
      logic [3:0]  en, flip;
      logic nb, rd_, rc;
      rw = $urandom; rr = $urandom; en = 4'($urandom); nb = 1'($urandom);
      rd_ = ($urandom % 4) != 0; rc = ($urandom % 4) != 0;
      flip = (($urandom % 2) == 0) ? 4'($urandom) : 4'h0;
      cyc(rd_ && rc ? (nb ? "R6 random narrow" : "R4 random read") : "R7 random idle",
          0, rd_, rc, nb, en, rw, rr, ref_par(rr) ^ flip);
    end
    cyc("R8 final", 0, 0, 0, 0, 4'h0, 32'h0, 32'h0, 4'h0);
    @(negedge clk);
    check1(tag_next, {31'd0, chk_n}, {31'd0, exp_next});
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule